// File: doc/BRIEF.md
# Multi-Bit Truncation First-Order Delta-Sigma Modulator

This block turns a wide unsigned control word into a short stream of output codes whose long-run average tracks the input divided by a power of two. It holds a small residue register of `FRAC_W` bits. Each clock, the residue is added to the input word `u_i`. The upper `OUT_W` bits of that `OUT_W+FRAC_W`-bit sum become the next output code. The lower `FRAC_W` bits are kept as the new residue. The accumulator therefore acts as its own quantizer. The truncation error is fed back with one cycle of delay, which gives it a first-order high-pass shape, while the input passes through scaled by `2^-FRAC_W`.

Typical uses are fractional division-ratio control in a synthesizer and driving a small multi-bit DAC. The sum stays in range only while `u_i <= 2^(OUT_W+FRAC_W) - 2^FRAC_W`. The block watches that bound. An input above it raises a sticky overflow flag. If the sum then carries out of its width, it is clamped to all ones instead of wrapping, so the output never jumps from its top code to zero.

Top module: `trunc_dsm1`

## Requirements
- R1: While `rst_n` is low and after its release, `v_o` is 0, `ovf_o` is 0 and the residue is 0. With a zero residue, the first code after reset is `floor(u_i / 2^FRAC_W)`.
- R2: The code on `v_o` after a rising edge is `floor((u_i + residue) / 2^FRAC_W)`, where `u_i` is the value sampled at that edge and residue is the value held before that edge.
- R3: At each edge the residue is replaced by the low `FRAC_W` bits of the (possibly clamped) sum, and it is used at the next edge.
- R4: For `u_i <= 2^(OUT_W+FRAC_W) - 2^FRAC_W`, the sum never carries out, the clamp never acts, and `ovf_o` is not set.
- R5: An edge that samples `u_i > 2^(OUT_W+FRAC_W) - 2^FRAC_W` sets `ovf_o` from the following cycle onward. `ovf_o` stays 1 until reset, whatever the input does.
- R6: When `u_i + residue >= 2^(OUT_W+FRAC_W)`, the sum is clamped to `2^(OUT_W+FRAC_W) - 1`. The code is then all ones and the residue becomes `2^FRAC_W - 1`.
- R7: With the residue at zero after reset and a constant in-range `u_i`, the codes produced over `K * 2^FRAC_W` consecutive cycles add up to exactly `K * u_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| u_i | input | OUT_W+FRAC_W | Unsigned control word, scaled by 2^-FRAC_W |
| v_o | output | OUT_W | Registered output code |
| ovf_o | output | 1 | Sticky flag: an input above the stable bound was seen |

## Verification
The bench builds the block with `OUT_W = 2` and `FRAC_W = 4`. This gives a 6-bit input, a stable bound of 48 and a residue cycle of 16 steps. The whole input range, including every over-bound value from 49 to 63, can be reached with random stimulus. Complete averaging windows take only a few dozen cycles. With such a narrow word, clamped sums also come up often, and each one is checked against a bench model of the residue.

// File: rtl/trunc_dsm1_pkg.sv
package trunc_dsm1_pkg;

   // Largest input for which the residue-plus-input sum cannot leave its width.
   function automatic longint unsigned stable_limit(input int unsigned total_w,
                                                    input int unsigned frac_w);
      longint unsigned full;
      longint unsigned step;
      full = longint'(1) << total_w;
      step = longint'(1) << frac_w;
      return full - step;
   endfunction

   // Number of cycles over which the residue sequence returns to its start.
   function automatic longint unsigned residue_period(input int unsigned frac_w);
      return longint'(1) << frac_w;
   endfunction

endpackage

// File: rtl/trunc_range_chk.sv
// Flags an input word above the stable bound 2^W - 2^F.
// Above the bound means: all upper bits are one and any low bit is one.
module trunc_range_chk #(
   parameter int unsigned OUT_W  = 2,
   parameter int unsigned FRAC_W = 4,
   localparam int unsigned TOT_W = OUT_W + FRAC_W
) (
   input  logic [TOT_W-1:0] word_i,
   output logic             over_o
);
   logic hi_full;
   logic lo_any;

   assign hi_full = &word_i[TOT_W-1:FRAC_W];

   generate
      if (FRAC_W == 1) begin : g_lo_single
         assign lo_any = word_i[0];
      end else begin : g_lo_multi
         assign lo_any = |word_i[FRAC_W-1:0];
      end
   endgenerate

   assign over_o = hi_full & lo_any;
endmodule

// File: rtl/trunc_acc.sv
// Adds the residue to the input word. Clamps at all ones when the sum carries out.
// Splits the result into the next code and the next residue.
module trunc_acc #(
   parameter int unsigned OUT_W  = 2,
   parameter int unsigned FRAC_W = 4,
   localparam int unsigned TOT_W = OUT_W + FRAC_W
) (
   input  logic [TOT_W-1:0]  word_i,
   input  logic [FRAC_W-1:0] res_i,
   output logic [OUT_W-1:0]  code_o,
   output logic [FRAC_W-1:0] res_o,
   output logic              carry_o
);
   logic [TOT_W:0]   raw_sum;
   logic [TOT_W-1:0] kept_sum;

   always_comb begin
      raw_sum = {1'b0, word_i} + {{(OUT_W+1){1'b0}}, res_i};
   end

   assign carry_o  = raw_sum[TOT_W];
   assign kept_sum = carry_o ? {TOT_W{1'b1}} : raw_sum[TOT_W-1:0];
   assign code_o   = kept_sum[TOT_W-1:FRAC_W];
   assign res_o    = kept_sum[FRAC_W-1:0];
endmodule

// File: rtl/trunc_state.sv
// State of the modulator: the residue, the output code and the sticky overflow flag.
module trunc_state #(
   parameter int unsigned OUT_W  = 2,
   parameter int unsigned FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OUT_W-1:0]  code_d,
   input  logic [FRAC_W-1:0] res_d,
   input  logic              over_d,
   output logic [OUT_W-1:0]  code_q,
   output logic [FRAC_W-1:0] res_q,
   output logic              ovf_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         res_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         code_q <= code_d;
         res_q  <= res_d;
         ovf_q  <= ovf_q | over_d;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q); // R5
   AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      over_d |=> ovf_q); // R5
endmodule

// File: rtl/trunc_dsm1.sv
module trunc_dsm1 #(
   parameter int unsigned OUT_W  = 2,
   parameter int unsigned FRAC_W = 4,
   localparam int unsigned TOT_W = OUT_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOT_W-1:0] u_i,
   output logic [OUT_W-1:0] v_o,
   output logic             ovf_o
);
   import trunc_dsm1_pkg::*;

   localparam longint unsigned BOUND = stable_limit(TOT_W, FRAC_W);

   generate
      if (OUT_W < 1 || OUT_W > 16) begin : g_bad_out
         $error("OUT_W must lie in 1..16");
      end
      if (FRAC_W < 1 || FRAC_W > 32) begin : g_bad_frac
         $error("FRAC_W must lie in 1..32");
      end
   endgenerate

   logic [FRAC_W-1:0] res_q;
   logic [FRAC_W-1:0] res_d;
   logic [OUT_W-1:0]  code_d;
   logic              sum_carry;
   logic              over_bound;

   trunc_range_chk #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_chk (
      .word_i (u_i),
      .over_o (over_bound)
   );

   trunc_acc #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_acc (
      .word_i  (u_i),
      .res_i   (res_q),
      .code_o  (code_d),
      .res_o   (res_d),
      .carry_o (sum_carry)
   );

   trunc_state #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_d (code_d),
      .res_d  (res_d),
      .over_d (over_bound),
      .code_q (v_o),
      .res_q  (res_q),
      .ovf_q  (ovf_o)
   );

   AST_NO_CARRY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(u_i) <= BOUND) |-> !sum_carry); // R4
   AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      sum_carry |=> (v_o == {OUT_W{1'b1}})); // R6
   AST_SAT_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
      sum_carry |=> (res_q == {FRAC_W{1'b1}})); // R6
   AST_CARRY_ONLY_OVER: assert property (@(posedge clk) disable iff (!rst_n)
      sum_carry |=> ovf_o); // R4
endmodule

// File: tb/sim_trunc_dsm1.sv
module sim_trunc_dsm1;
   localparam int OW = 2;
   localparam int FW = 4;
   localparam int TW = OW + FW;
   localparam int LIMIT = (1 << TW) - (1 << FW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] u = '0;
   logic [OW-1:0] v;
   logic          ovf;

   int n_run = 0;
   int n_bad = 0;
   int m_res = 0;
   int m_ovf = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   trunc_dsm1 #(.OUT_W(OW), .FRAC_W(FW)) u0 (
      .clk(clk), .rst_n(rst_n), .u_i(u), .v_o(v), .ovf_o(ovf)
   );

   function automatic int exp_sum(input int word, input int res);
      int s;
      s = word + res;
      if (s >= (1 << TW)) s = (1 << TW) - 1;
      return s;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      u = '0;
      m_res = 0;
      m_ovf = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive one word at the negedge, let one edge pass, then compare with the model.
   task automatic step(input int word, input string req);
      int s;
      @(negedge clk);
      u = word[TW-1:0];
      s = exp_sum(word, m_res);
      m_res = s % (1 << FW);
      if (word > LIMIT) m_ovf = 1;
      @(posedge clk);
      #1;
      chk(req, int'(v), s >> FW);
      chk(req, int'(ovf), m_ovf);
   endtask

   task automatic window(input int word, input int k);
      int acc;
      acc = 0;
      do_reset();
      u = word[TW-1:0];
      for (int i = 0; i < k * (1 << FW); i++) begin
         @(posedge clk);
         #1;
         acc += int'(v);
      end
      chk("R7", acc, word * k);
      chk("R7", int'(ovf), 0);
   endtask

   initial begin
      int unsigned seed;
      int w;
      seed = 32'd1234;
      void'($urandom(seed));

      // R1: values held while reset is active
      #12;
      chk("R1", int'(v), 0);
      chk("R1", int'(ovf), 0);
      rst_n = 1'b1;

      // build up a residue, then reset and confirm the residue was cleared
      step(13, "R2");
      step(13, "R2");
      do_reset();
      chk("R1", int'(v), 0);
      step(15, "R1");   // zero residue: floor(15/16)=0
      step(1, "R3");    // residue 15 + 1 gives code 1, residue 0
      step(0, "R3");

      // R2/R3/R4: random in-range stimulus
      for (int i = 0; i < 400; i++) begin
         w = int'($urandom_range(LIMIT, 0));
         step(w, "R2");
      end
      step(LIMIT, "R4");
      step(LIMIT, "R4");
      step(0, "R4");
      chk("R4", int'(ovf), 0);

      // R6 and R5: over-bound input, clamping, stickiness
      step(LIMIT + 1, "R6");
      step(63, "R6");
      chk("R6", int'(v), (1 << OW) - 1);
      step(0, "R6");   // residue 15 left by the clamp: code 0
      step(1, "R6");   // 15 + 1 gives code 1
      for (int i = 0; i < 20; i++) step(int'($urandom_range(LIMIT, 0)), "R5");
      chk("R5", int'(ovf), 1);

      // mixed random including over-bound values
      do_reset();
      for (int i = 0; i < 300; i++) begin
         w = int'($urandom_range((1 << TW) - 1, 0));
         step(w, "R6");
      end

      // R7: averaging over full residue periods
      window(37, 3);
      window(LIMIT, 2);
      window(5, 4);
      window(0, 1);
      for (int i = 0; i < 5; i++) window(int'($urandom_range(LIMIT, 0)), 2);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end
endmodule